// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. Each cycle it receives an operation code, the accumulator byte, a second operand byte and an incoming carry bit. It produces a result byte combinationally, together with a strobe that says whether the accumulator should take that result. It also computes a new flag byte and holds it in a register that loads only when the caller pulses the flag write enable.

Each operation class touches its own subset of flags and leaves the rest as they were in the register. The parity/overflow bit means signed overflow for arithmetic and even parity for logic operations. The operation codes are 4-bit values: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 increment, 9 decrement, 10 complement, 11 negate, 12 set carry, 13 complement carry. Codes 14 and 15 are reserved.

The flag byte places sign at bit 7, zero at bit 6, half carry at bit 4, parity/overflow at bit 2, add/subtract (N) at bit 1 and carry at bit 0. Bits 5 and 3 are always 0. Operand fetch, instruction decode, decimal adjust and 16-bit arithmetic are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: The flag register resets to 0x00 on the asynchronous active-low reset. Flag bits 5 and 3 always read 0. Sign is bit 7, zero is bit 6, half carry is bit 4, parity/overflow is bit 2, N is bit 1 and carry is bit 0.
- R2: The flag register loads the new flag byte on a rising clock edge only when flag_we_i is 1. Otherwise it holds its value.
- R3: Add (code 0) gives A+B. Add with carry (code 1) gives A+B+carry_i. Both clear N and set S, Z, half carry (carry out of bit 3), signed overflow in P/V, and C (carry out of bit 7).
- R4: Subtract (code 2) gives A-B. Subtract with carry (code 3) gives A-B-carry_i. Negate (code 11) gives 0-A, so its carry is set exactly when A is nonzero. All three set N and set S, Z, half carry (borrow from bit 4), signed overflow in P/V, and C (borrow).
- R5: Compare (code 4) sets the flags exactly as subtract would for A-B. It leaves result_o equal to acc_i and holds acc_we_o at 0.
- R6: AND (5), OR (6) and XOR (7) set S and Z from the result and put even parity of the result in P/V (1 when the count of ones is even). They clear N and C. Half carry is 1 for AND and 0 for OR and XOR.
- R7: Increment (code 8) and decrement (code 9) update S, Z, half carry and signed overflow and keep the stored carry. Increment clears N and decrement sets N.
- R8: Complement (code 10) returns the bitwise inverse of A and sets half carry and N. It leaves S, Z, P/V and C unchanged.
- R9: Set carry (code 12) makes C 1 and clears half carry and N. Complement carry (code 13) inverts C, copies the old C into half carry and clears N. Both leave S, Z and P/V unchanged, return A and hold acc_we_o at 0.
- R10: acc_we_o is 1 for codes 0-3 and 5-11. Reserved codes 14 and 15 return A, hold acc_we_o at 0 and leave the flag register unchanged even when flag_we_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand byte |
| carry_i | input | 1 | Carry used by add/subtract with carry |
| flag_we_i | input | 1 | Flag register load strobe |
| result_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Accumulator should take result_o |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench targets the boundaries where flags change meaning:
- **0x7F+1 and 0x80-1.** These must raise overflow. A design that reported parity or an unsigned carry in P/V would show 0 there.
- **Borrow and half borrow.** 0x00-0x01 and 0x10-0x0F with a carry in check the subtract sense of both. An inverted borrow would flip C and H.
- **Carry preservation.** Increment of 0xFF is applied after set carry, and decrement after complement carry. This catches a design that lets these ops write C.
- **Compare, reserved codes and a held strobe.** These check at the ports that the accumulator strobe stays low and the flag byte does not move.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned FLAG_W = 8;
  localparam int unsigned F_S  = 7;
  localparam int unsigned F_Z  = 6;
  localparam int unsigned F_H  = 4;
  localparam int unsigned F_PV = 2;
  localparam int unsigned F_N  = 1;
  localparam int unsigned F_C  = 0;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8;
  localparam logic [3:0] OP_DEC = 4'd9;
  localparam logic [3:0] OP_CPL = 4'd10;
  localparam logic [3:0] OP_NEG = 4'd11;
  localparam logic [3:0] OP_SCF = 4'd12;
  localparam logic [3:0] OP_CCF = 4'd13;

  typedef struct packed {
    logic carry;
    logic half;
    logic ovf;
  } arith_st_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned HB = DW / 2
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output arith_st_t     st_o
);
  localparam int unsigned LW = HB + 1;
  localparam int unsigned UW = DW - HB + 1;

  logic [DW-1:0] bx;
  logic          cx;
  logic [LW-1:0] lo;
  logic [UW-1:0] hi;

  // subtract as a + ~b + ~borrow; carries invert into borrows
  assign bx = b_i ^ {DW{sub_i}};
  assign cx = cin_i ^ sub_i;
  assign lo = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + LW'(cx);
  assign hi = {1'b0, a_i[DW-1:HB]} + {1'b0, bx[DW-1:HB]} + UW'(lo[HB]);

  assign sum_o    = {hi[UW-2:0], lo[HB-1:0]};
  assign st_o.carry = hi[UW-1] ^ sub_i;
  assign st_o.half  = lo[HB] ^ sub_i;
  assign st_o.ovf   = (a_i[DW-1] == bx[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          par_even_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

  assign par_even_o = ~^res_o;
endmodule

// File: rtl/acc_alu_flagmux.sv
module acc_alu_flagmux
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]        op_i,
  input  logic [DW-1:0]     sum_i,
  input  arith_st_t         st_i,
  input  logic [DW-1:0]     lres_i,
  input  logic              par_i,
  input  logic [FLAG_W-1:0] flags_q_i,
  output logic [FLAG_W-1:0] flags_d_o
);
  logic [FLAG_W-1:0] f;

  always_comb begin
    f = flags_q_i;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
        f[F_S]  = sum_i[DW-1];
        f[F_Z]  = (sum_i == '0);
        f[F_H]  = st_i.half;
        f[F_PV] = st_i.ovf;
        f[F_N]  = (op_i != OP_ADD) && (op_i != OP_ADC);
        f[F_C]  = st_i.carry;
      end
      OP_INC, OP_DEC: begin
        f[F_S]  = sum_i[DW-1];
        f[F_Z]  = (sum_i == '0);
        f[F_H]  = st_i.half;
        f[F_PV] = st_i.ovf;
        f[F_N]  = (op_i == OP_DEC);
      end
      OP_AND, OP_OR, OP_XOR: begin
        f[F_S]  = lres_i[DW-1];
        f[F_Z]  = (lres_i == '0);
        f[F_H]  = (op_i == OP_AND);
        f[F_PV] = par_i;
        f[F_N]  = 1'b0;
        f[F_C]  = 1'b0;
      end
      OP_CPL: begin
        f[F_H] = 1'b1;
        f[F_N] = 1'b1;
      end
      OP_SCF: begin
        f[F_C] = 1'b1;
        f[F_H] = 1'b0;
        f[F_N] = 1'b0;
      end
      OP_CCF: begin
        f[F_H] = flags_q_i[F_C];
        f[F_C] = ~flags_q_i[F_C];
        f[F_N] = 1'b0;
      end
      default: ;
    endcase
    f[5] = 1'b0;
    f[3] = 1'b0;
    flags_d_o = f;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [DW-1:0]     acc_i,
  input  logic [DW-1:0]     opnd_i,
  input  logic              carry_i,
  input  logic              flag_we_i,
  output logic [DW-1:0]     result_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [DW-1:0]     as_a, as_b, sum, lres;
  logic              as_cin, as_sub, par;
  arith_st_t         st;
  logic [FLAG_W-1:0] flags_q, flags_d;

  // adder operand steering
  always_comb begin
    as_a   = acc_i;
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op_i)
      OP_ADC: as_cin = carry_i;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = carry_i; end
      OP_INC: begin as_b = '0; as_cin = 1'b1; end
      OP_DEC: begin as_b = '0; as_cin = 1'b1; as_sub = 1'b1; end
      OP_NEG: begin as_a = '0; as_b = acc_i; as_sub = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(sum), .st_o(st)
  );

  acc_alu_logic #(.DW(DW)) u_logic (
    .op_i(op_i), .a_i(acc_i), .b_i(opnd_i), .res_o(lres), .par_even_o(par)
  );

  acc_alu_flagmux #(.DW(DW)) u_flagmux (
    .op_i(op_i), .sum_i(sum), .st_i(st), .lres_i(lres), .par_i(par),
    .flags_q_i(flags_q), .flags_d_o(flags_d)
  );

  always_comb begin
    result_o = acc_i;
    acc_we_o = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC, OP_NEG: begin
        result_o = sum;
        acc_we_o = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        result_o = lres;
        acc_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flags_q <= '0;
    else if (flag_we_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        op_i,
  input logic [DW-1:0]     acc_i,
  input logic [DW-1:0]     opnd_i,
  input logic              carry_i,
  input logic              flag_we_i,
  input logic [DW-1:0]     result_o,
  input logic              acc_we_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic is_sub, is_logic;
  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SBC) || (op_i == OP_CMP) || (op_i == OP_NEG);
  assign is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR);

  a_r1_pad_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[5] && !flags_o[3]);

  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  a_r3_add_clears_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && (op_i == OP_ADD || op_i == OP_ADC) |=> !flags_o[F_N]);

  a_r4_sub_sets_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && is_sub |=> flags_o[F_N]);

  a_r5_cmp_keeps_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CMP |-> !acc_we_o && result_o == acc_i);

  a_r6_logic_clears_nc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && is_logic |=> !flags_o[F_N] && !flags_o[F_C]);

  a_r7_incdec_keeps_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[F_C] == $past(flags_o[F_C]));

  a_r8_cpl_sets_hn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i == OP_CPL |=> flags_o[F_H] && flags_o[F_N] &&
    flags_o[F_C] == $past(flags_o[F_C]) && flags_o[F_Z] == $past(flags_o[F_Z]));

  a_r9_scf_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && op_i == OP_SCF |=> flags_o[F_C] && !flags_o[F_H] && !flags_o[F_N]);

  a_r10_reserved_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i >= 4'd14 |=> $stable(flags_o));

  a_r10_reserved_no_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i >= 4'd14 |-> !acc_we_o);
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
  .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
  .acc_we_o(acc_we_o), .flags_o(flags_o)
);

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] acc_i = 8'd0, opnd_i = 8'd0;
  logic       carry_i = 1'b0, flag_we_i = 1'b0;
  logic [7:0] result_o, flags_o;
  logic       acc_we_o;

  int vectors = 0, errs = 0;
  bit done = 0;
  logic [7:0] exp_flags = 8'h00;

  always #4 clk_i = ~clk_i;

  acc_alu dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
    .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // reference model built from the requirement text
  function automatic void model(input logic [3:0] op, input logic [7:0] a, b, input logic c,
                                input logic [7:0] fin, output logic [7:0] r, output logic we,
                                output logic [7:0] fo);
    int x, y, k, full, sres;
    logic h, v, cy;
    fo = fin; r = a; we = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd8: begin
        x = a; y = (op == 4'd8) ? 1 : int'(b); k = (op == 4'd1) ? int'(c) : 0;
        full = x + y + k; r = 8'(full);
        h = ((x % 16) + (y % 16) + k) > 15;
        sres = sx(x) + sx(y) + k; v = (sres > 127) || (sres < -128);
        cy = (op == 4'd8) ? fin[0] : (full > 255);
        fo = {r[7], r == 8'h00, 1'b0, h, 1'b0, v, 1'b0, cy};
        we = 1'b1;
      end
      4'd2, 4'd3, 4'd4, 4'd9, 4'd11: begin
        x = (op == 4'd11) ? 0 : int'(a);
        y = (op == 4'd11) ? int'(a) : (op == 4'd9) ? 1 : int'(b);
        k = (op == 4'd3) ? int'(c) : 0;
        full = x - y - k; r = 8'(full);
        h = ((x % 16) - (y % 16) - k) < 0;
        sres = sx(x) - sx(y) - k; v = (sres > 127) || (sres < -128);
        cy = (op == 4'd9) ? fin[0] : (full < 0);
        fo = {r[7], r == 8'h00, 1'b0, h, 1'b0, v, 1'b1, cy};
        we = 1'b1;
        if (op == 4'd4) begin r = a; we = 1'b0; end
      end
      4'd5, 4'd6, 4'd7: begin
        r = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) : (a ^ b);
        fo = {r[7], r == 8'h00, 1'b0, op == 4'd5, 1'b0, ~^r, 1'b0, 1'b0};
        we = 1'b1;
      end
      4'd10: begin r = ~a; we = 1'b1; fo = fin | 8'h12; end
      4'd12: fo = (fin & 8'hED) | 8'h01;
      4'd13: fo = {fin[7:5], fin[0], fin[3:2], 1'b0, ~fin[0]};
      default: ;
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [7:0] a, b, input logic c,
                       input logic we, input string req);
    logic [7:0] er, ef; logic ew;
    model(op, a, b, c, exp_flags, er, ew, ef);
    if (!we) ef = exp_flags;
    @(negedge clk_i);
    op_i = op; acc_i = a; opnd_i = b; carry_i = c; flag_we_i = we;
    #1;
    chk(result_o, er, req, "result");
    chk({7'd0, acc_we_o}, {7'd0, ew}, req, "acc_we");
    @(negedge clk_i);
    flag_we_i = 1'b0;
    chk(flags_o, ef, req, "flags");
    exp_flags = ef;
  endtask

  task automatic t_reset;
    chk(flags_o, 8'h00, "R1", "reset flags");
  endtask

  task automatic t_add;
    apply(4'd0, 8'h12, 8'h34, 1'b0, 1'b1, "R3");
    apply(4'd0, 8'h7F, 8'h01, 1'b0, 1'b1, "R3");
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, "R3");
    apply(4'd1, 8'h0F, 8'h00, 1'b1, 1'b1, "R3");
    apply(4'd1, 8'hFF, 8'h00, 1'b1, 1'b1, "R3");
    apply(4'd0, 8'h80, 8'h80, 1'b1, 1'b1, "R3");
  endtask

  task automatic t_sub;
    apply(4'd2, 8'h05, 8'h03, 1'b0, 1'b1, "R4");
    apply(4'd2, 8'h00, 8'h01, 1'b0, 1'b1, "R4");
    apply(4'd2, 8'h80, 8'h01, 1'b0, 1'b1, "R4");
    apply(4'd3, 8'h10, 8'h0F, 1'b1, 1'b1, "R4");
    apply(4'd11, 8'h01, 8'h00, 1'b0, 1'b1, "R4");
    apply(4'd11, 8'h80, 8'h00, 1'b0, 1'b1, "R4");
    apply(4'd11, 8'h00, 8'h00, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_cmp;
    apply(4'd4, 8'h42, 8'h42, 1'b0, 1'b1, "R5");
    apply(4'd4, 8'h10, 8'h20, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_logic;
    apply(4'd5, 8'hF0, 8'h0F, 1'b0, 1'b1, "R6");
    apply(4'd6, 8'h01, 8'h02, 1'b0, 1'b1, "R6");
    apply(4'd7, 8'h55, 8'hAA, 1'b0, 1'b1, "R6");
    apply(4'd7, 8'h81, 8'h00, 1'b1, 1'b1, "R6");
  endtask

  task automatic t_incdec;
    apply(4'd12, 8'h00, 8'h00, 1'b0, 1'b1, "R9");
    apply(4'd8, 8'hFF, 8'h00, 1'b0, 1'b1, "R7");
    apply(4'd8, 8'h7F, 8'h00, 1'b0, 1'b1, "R7");
    apply(4'd13, 8'h00, 8'h00, 1'b0, 1'b1, "R9");
    apply(4'd9, 8'h01, 8'h00, 1'b1, 1'b1, "R7");
    apply(4'd9, 8'h80, 8'h00, 1'b0, 1'b1, "R7");
    apply(4'd9, 8'h00, 8'h00, 1'b0, 1'b1, "R7");
  endtask

  task automatic t_cpl;
    apply(4'd2, 8'h00, 8'h01, 1'b0, 1'b1, "R4");
    apply(4'd10, 8'h5A, 8'h00, 1'b0, 1'b1, "R8");
  endtask

  task automatic t_carry_ops;
    apply(4'd12, 8'h33, 8'h00, 1'b0, 1'b1, "R9");
    apply(4'd13, 8'h33, 8'h00, 1'b0, 1'b1, "R9");
    apply(4'd13, 8'h33, 8'h00, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_reserved;
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1, "R10");
    apply(4'd14, 8'hA5, 8'h3C, 1'b1, 1'b1, "R10");
    apply(4'd15, 8'h00, 8'hFF, 1'b0, 1'b1, "R10");
  endtask

  task automatic t_hold;
    apply(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, "R2");
    apply(4'd5, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
    apply(4'd0, 8'h7F, 8'h01, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 140; i++)
      apply(4'(i % 14), 8'(i * 37 + 5), 8'(i * 91 + 3), i[1], 1'b1, "R3");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #10;
    t_reset;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_add;
    t_sub;
    t_cmp;
    t_logic;
    t_incdec;
    t_cpl;
    t_carry_ops;
    t_reserved;
    t_hold;
    t_sweep;
    chk(flags_o & 8'h28, 8'h00, "R1", "pad bits");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule